// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator processor. Each cycle that its strobe is high it takes an operation code, two data bytes and the present flag byte, and one clock later it presents a result byte, a new flag byte and a four-bit condition vector that branch logic can test directly. While the strobe is low the registered outputs hold their last values.

The flag byte carries sign, zero, half-carry, parity/overflow, add/subtract and carry. The carry bit links successive additions and subtractions for multi-byte arithmetic. It serves as the link bit for rotates and is cleared by logical operations. The add/subtract bit records which kind of arithmetic ran last, for a later decimal-adjust step that lives outside this block. One bit reports signed overflow after arithmetic and even parity after logic and rotate operations.

Top module: `acc_alu8`

## Requirements
- R1: While reset is high and on the first cycle after it, result_o, flags_o, cond_o and out_valid are all zero.
- R2: An operation strobed with in_valid on one rising edge appears on result_o/flags_o with out_valid high after that edge. A cycle without in_valid drops out_valid and leaves result_o and flags_o unchanged.
- R3: Flag byte layout: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 add/subtract, bit 0 carry. Bits 3 and 5 of flags_o are always 0.
- R4: ADD (code 0) gives a+b and ADC (code 1) gives a+b+carry_in. Carry is set on a carry out of bit 7, half-carry on a carry out of bit 3, and add/subtract is cleared.
- R5: SUB (code 2) gives a-b and SBC (code 3) gives a-b-carry_in. Carry is set when a borrow is needed, half-carry on a borrow into bit 3, and add/subtract is set.
- R6: For codes 0 to 3, parity/overflow is set exactly when the signed result lies outside -128..+127.
- R7: AND (4), OR (5) and XOR (6) clear carry, half-carry and add/subtract, and set parity/overflow when the result has an even number of 1 bits.
- R8: Left rotates and shifts load carry from the old bit 7. RLC (7) moves bit 7 into bit 0, RL (9) moves the old carry into bit 0, and SLA (11) fills bit 0 with 0.
- R9: Right rotates and shifts load carry from the old bit 0. RRC (8) moves bit 0 into bit 7, RR (10) moves the old carry into bit 7, SRA (12) keeps bit 7, and SRL (13) fills bit 7 with 0.
- R10: For codes 7 to 13, half-carry and add/subtract are cleared and parity/overflow reports even parity of the result.
- R11: SCF (14) sets carry and CCF (15) inverts the incoming carry. Both clear half-carry and add/subtract, keep sign, zero and parity/overflow from flags_i, and pass operand a to result_o.
- R12: For codes 0 to 13, zero is set exactly when the result byte is 0, and sign equals result bit 7.
- R13: cond_o is {sign, parity/overflow, zero, carry} of flags_o, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: perform the operation this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| out_valid | output | 1 | Result and flags were updated on the last edge |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| cond_o | output | 4 | Testable conditions {S, P/V, Z, C} |

## Verification
Signed overflow and the half-carry or half-borrow come from different stages of one addition, and both can come out set by the same operation. The operand pairs 0x7F+0x01 and 0x80-0x01 set both at once. 0xFF+0x01 and 0x00-0x01 instead raise carry and half-carry with overflow clear, and the zero or sign flag changes in the same cycle. A scoreboard model computes the whole flag byte for each case, with carry-in both low and high. Any bit that shows up on the wrong side of such a pair counts as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 4;
    localparam int CNDW = 4;

    // flag byte bit positions
    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_H  = 4;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,
        OP_RLC = 4'd7,  OP_RRC = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10,
        OP_SLA = 4'd11, OP_SRA = 4'd12, OP_SRL = 4'd13,
        OP_SCF = 4'd14, OP_CCF = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flag_t;

    typedef struct packed {
        word_t res;
        flag_t fl;
    } unit_out_t;

    function automatic word_t pack_flags(flag_t f);
        word_t w;
        w        = '0;
        w[FB_S]  = f.s;
        w[FB_Z]  = f.z;
        w[FB_H]  = f.h;
        w[FB_PV] = f.pv;
        w[FB_N]  = f.n;
        w[FB_C]  = f.c;
        return w;
    endfunction

    function automatic flag_t unpack_flags(word_t w);
        flag_t f;
        f.s  = w[FB_S];
        f.z  = w[FB_Z];
        f.h  = w[FB_H];
        f.pv = w[FB_PV];
        f.n  = w[FB_N];
        f.c  = w[FB_C];
        return f;
    endfunction

    // 1 when the byte holds an even number of ones
    function automatic logic even_parity(word_t w);
        return ~^w;
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_carry_op(alu_op_e op);
        return (op == OP_SCF) || (op == OP_CCF);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  word_t     a,
    input  word_t     b,
    input  logic      cin,
    input  logic      use_cin,
    input  logic      do_sub,
    output unit_out_t out
);
    logic          ci;
    logic [DW:0]   full;
    logic [NIB:0]  low;
    word_t         r;
    logic          ovf;

    assign ci = cin & use_cin;

    always_comb begin
        if (do_sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ci};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, ci};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, ci};
        end
    end

    assign r = full[DW-1:0];

    // signed overflow from operand and result sign bits
    always_comb begin
        if (do_sub)
            ovf = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
        else
            ovf = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]);
    end

    always_comb begin
        out.res   = r;
        out.fl.s  = r[DW-1];
        out.fl.z  = (r == '0);
        out.fl.h  = low[NIB];
        out.fl.pv = ovf;
        out.fl.n  = do_sub;
        out.fl.c  = full[DW];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  word_t     b,
    output unit_out_t out
);
    word_t r;

    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            default: r = a ^ b;
        endcase
    end

    always_comb begin
        out.res   = r;
        out.fl.s  = r[DW-1];
        out.fl.z  = (r == '0);
        out.fl.h  = 1'b0;
        out.fl.pv = even_parity(r);
        out.fl.n  = 1'b0;
        out.fl.c  = 1'b0;
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  logic      cin,
    output unit_out_t out
);
    logic  go_left;
    logic  fill;
    logic  cout;
    word_t r;

    assign go_left = (op == OP_RLC) || (op == OP_RL) || (op == OP_SLA);

    // bit entering the vacated end
    always_comb begin
        unique case (op)
            OP_RLC:  fill = a[DW-1];
            OP_RL:   fill = cin;
            OP_RRC:  fill = a[0];
            OP_RR:   fill = cin;
            OP_SRA:  fill = a[DW-1];
            default: fill = 1'b0;
        endcase
    end

    always_comb begin
        if (go_left) begin
            r    = {a[DW-2:0], fill};
            cout = a[DW-1];
        end else begin
            r    = {fill, a[DW-1:1]};
            cout = a[0];
        end
    end

    always_comb begin
        out.res   = r;
        out.fl.s  = r[DW-1];
        out.fl.z  = (r == '0);
        out.fl.h  = 1'b0;
        out.fl.pv = even_parity(r);
        out.fl.n  = 1'b0;
        out.fl.c  = cout;
    end
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
    import alu8_pkg::*;
(
    input  word_t            flags,
    output logic [CNDW-1:0]  cond
);
    assign cond = {flags[FB_S], flags[FB_PV], flags[FB_Z], flags[FB_C]};
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  op_i,
    input  logic [7:0]  a_i,
    input  logic [7:0]  b_i,
    input  logic [7:0]  flags_i,
    output logic        out_valid,
    output logic [7:0]  result_o,
    output logic [7:0]  flags_o,
    output logic [3:0]  cond_o
);
    alu_op_e   op;
    flag_t     fin;
    unit_out_t arith_q, logic_q, rot_q, cfl_q, sel;
    logic      sub_op, carry_used;
    word_t     res_r, flg_r;
    logic      vld_r;

    assign op         = alu_op_e'(op_i);
    assign fin        = unpack_flags(flags_i);
    assign sub_op     = (op == OP_SUB) || (op == OP_SBC);
    assign carry_used = (op == OP_ADC) || (op == OP_SBC);

    alu8_addsub u_addsub (
        .a       (a_i),
        .b       (b_i),
        .cin     (fin.c),
        .use_cin (carry_used),
        .do_sub  (sub_op),
        .out     (arith_q)
    );

    alu8_logic u_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .out (logic_q)
    );

    alu8_rotate u_rotate (
        .op  (op),
        .a   (a_i),
        .cin (fin.c),
        .out (rot_q)
    );

    // carry set / complement keeps S, Z, P/V
    always_comb begin
        cfl_q.res   = a_i;
        cfl_q.fl    = fin;
        cfl_q.fl.h  = 1'b0;
        cfl_q.fl.n  = 1'b0;
        cfl_q.fl.c  = (op == OP_SCF) ? 1'b1 : ~fin.c;
    end

    always_comb begin
        if (is_arith(op))
            sel = arith_q;
        else if (is_logic(op))
            sel = logic_q;
        else if (is_carry_op(op))
            sel = cfl_q;
        else
            sel = rot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_r <= '0;
            flg_r <= '0;
            vld_r <= 1'b0;
        end else begin
            vld_r <= in_valid;
            if (in_valid) begin
                res_r <= sel.res;
                flg_r <= pack_flags(sel.fl);
            end
        end
    end

    alu8_cond u_cond (
        .flags (flg_r),
        .cond  (cond_o)
    );

    assign result_o  = res_r;
    assign flags_o   = flg_r;
    assign out_valid = vld_r;
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  op_i,
    input logic [7:0]  a_i,
    input logic [7:0]  b_i,
    input logic [7:0]  flags_i,
    input logic        out_valid,
    input logic [7:0]  result_o,
    input logic [7:0]  flags_o,
    input logic [3:0]  cond_o
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result_o) && $stable(flags_o));

    // R3
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flags_o[3] == 1'b0 && flags_o[5] == 1'b0);

    // R5
    sub_sets_n_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_i == OP_SUB || op_i == OP_SBC) |=> flags_o[FB_N]);

    // R7
    logic_clears_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
        |=> !flags_o[FB_C] && !flags_o[FB_H]);

    // R8
    left_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_i == OP_RLC || op_i == OP_RL || op_i == OP_SLA)
        |=> flags_o[FB_C] == $past(a_i[7]));

    // R9
    right_carry_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op_i == OP_RRC || op_i == OP_RR || op_i == OP_SRA || op_i == OP_SRL)
        |=> flags_o[FB_C] == $past(a_i[0]));

    // R11
    scf_sets_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_i == OP_SCF |=> flags_o[FB_C]);

    // R11
    ccf_inverts_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_i == OP_CCF |=> flags_o[FB_C] == !$past(flags_i[FB_C]));

    // R12
    zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_i < OP_SCF
        |=> flags_o[FB_Z] == (result_o == 8'h00) && flags_o[FB_S] == result_o[7]);

    // R13
    cond_map_chk: assert property (@(posedge clk) disable iff (rst)
        cond_o == {flags_o[FB_S], flags_o[FB_PV], flags_o[FB_Z], flags_o[FB_C]});
endmodule

bind acc_alu8 acc_alu8_chk u_chk (.*);

// File: tb/acc_alu8_tb.sv
module acc_alu8_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0, flags_i = '0;
    logic       out_valid;
    logic [7:0] result_o, flags_o;
    logic [3:0] cond_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit seen = 0;
    logic [7:0] last_res, last_flg;

    typedef struct { logic [3:0] op; logic [7:0] r; logic [7:0] f; } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    acc_alu8 u_dut (.*);

    function automatic string tag(logic [3:0] op);
        if (op <= 4'd1) return "R4";
        if (op <= 4'd3) return "R5";
        if (op <= 4'd6) return "R7";
        if (op == 4'd7 || op == 4'd9 || op == 4'd11) return "R8";
        if (op <= 4'd13) return "R9";
        return "R11";
    endfunction

    // behavioural reference: returns {result, flags}
    function automatic logic [15:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        int ia = a, ib = b, cin = f[0], s, r;
        int cs = 0, cz = 0, ch = 0, cv = 0, cn = 0, cc = 0;
        bit keep = 0;
        case (op)
            4'd0, 4'd1: begin
                if (op == 4'd0) cin = 0;
                s = ia + ib + cin; r = s & 255; cc = (s > 255);
                ch = (((ia & 15) + (ib & 15) + cin) > 15);
                cv = ((~(ia ^ ib)) & (ia ^ r) & 128) != 0;
            end
            4'd2, 4'd3: begin
                if (op == 4'd2) cin = 0;
                s = ia - ib - cin; r = s & 255; cc = (s < 0); cn = 1;
                ch = (((ia & 15) - (ib & 15) - cin) < 0);
                cv = ((ia ^ ib) & (ia ^ r) & 128) != 0;
            end
            4'd4: r = ia & ib;
            4'd5: r = ia | ib;
            4'd6: r = ia ^ ib;
            4'd7:  begin r = ((ia << 1) | (ia >> 7)) & 255; cc = ia >> 7; end
            4'd9:  begin r = ((ia << 1) | cin) & 255;        cc = ia >> 7; end
            4'd11: begin r = (ia << 1) & 255;                cc = ia >> 7; end
            4'd8:  begin r = (ia >> 1) | ((ia & 1) << 7);    cc = ia & 1; end
            4'd10: begin r = (ia >> 1) | (cin << 7);         cc = ia & 1; end
            4'd12: begin r = (ia >> 1) | (ia & 128);         cc = ia & 1; end
            4'd13: begin r = ia >> 1;                        cc = ia & 1; end
            4'd14: begin r = ia; cc = 1;        keep = 1; end
            default: begin r = ia; cc = 1 - cin; keep = 1; end
        endcase
        if (op >= 4'd4 && op <= 4'd13) cv = ($countones(r[7:0]) % 2 == 0);
        if (keep) begin cs = f[7]; cz = f[6]; cv = f[2]; end
        else begin cs = (r >> 7) & 1; cz = (r == 0); end
        return {r[7:0], cs[0], cz[0], 1'b0, ch[0], 1'b0, cv[0], cn[0], cc[0]};
    endfunction

    task automatic send(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        item_t it;
        logic [15:0] m;
        @(negedge clk);
        in_valid = 1'b1; op_i = op; a_i = a; b_i = b; flags_i = f;
        m = model(op, a, b, f);
        it.op = op; it.r = m[15:8]; it.f = m[7:0];
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_i = 4'($urandom); a_i = 8'($urandom); b_i = 8'($urandom); flags_i = 8'($urandom);
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as results emerge
    initial begin
        item_t it;
        @(negedge clk);
        while (!done) begin
            @(negedge clk);
            if (rst) continue;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    it = sb.pop_front();
                    check(result_o == it.r, tag(it.op), "result", result_o, it.r);
                    check(flags_o == it.f, tag(it.op), "flags", flags_o, it.f);
                    if (it.op <= 4'd3)
                        check(flags_o[2] == it.f[2], "R6", "overflow bit", flags_o[2], it.f[2]);
                    if (it.op <= 4'd13)
                        check(flags_o[6] == (result_o == 0) && flags_o[7] == result_o[7],
                              "R12", "zero/sign", flags_o, it.f);
                    check(flags_o[3] == 0 && flags_o[5] == 0, "R3", "unused bits", flags_o, it.f);
                    check(cond_o == {it.f[7], it.f[2], it.f[6], it.f[0]}, "R13", "cond",
                          cond_o, {it.f[7], it.f[2], it.f[6], it.f[0]});
                    if (it.op >= 4'd7 && it.op <= 4'd13)
                        check(flags_o[4] == 0 && flags_o[1] == 0, "R10", "h/n clear", flags_o, it.f);
                    last_res = it.r; last_flg = it.f; seen = 1;
                end
            end else if (seen) begin
                check(result_o == last_res && flags_o == last_flg, "R2", "hold while idle",
                      {result_o, flags_o}, {last_res, last_flg});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 0 && result_o == 0 && flags_o == 0 && cond_o == 0, "R1", "reset",
              {out_valid, result_o, flags_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && result_o == 0 && flags_o == 0, "R1", "after reset",
              {out_valid, result_o, flags_o}, 0);

        // R6 corner operands with carry-in low and high
        for (int c = 0; c < 2; c++) begin
            send(4'd0, 8'h7F, 8'h01, 8'(c));
            send(4'd2, 8'h80, 8'h01, 8'(c));
            send(4'd0, 8'hFF, 8'h01, 8'(c));
            send(4'd2, 8'h00, 8'h01, 8'(c));
            send(4'd1, 8'h7F, 8'h00, 8'(c));
            send(4'd3, 8'h80, 8'h00, 8'(c));
            send(4'd1, 8'hFF, 8'h00, 8'(c));
            send(4'd3, 8'h00, 8'h00, 8'(c));
        end
        idle(2);
        // R7 parity, R8/R9 edge patterns, R11 with all flags set/clear
        send(4'd4, 8'hF0, 8'h0F, 8'h00);
        send(4'd5, 8'h01, 8'h00, 8'h01);
        send(4'd6, 8'hAA, 8'h55, 8'hFF);
        for (int op = 7; op <= 13; op++) begin
            send(4'(op), 8'h81, 8'h00, 8'h00);
            send(4'(op), 8'h01, 8'h00, 8'h01);
            send(4'(op), 8'h80, 8'h00, 8'h01);
        end
        send(4'd14, 8'h33, 8'h00, 8'hC4);
        send(4'd15, 8'h33, 8'h00, 8'hC5);
        send(4'd15, 8'h00, 8'h00, 8'h00);
        idle(3);
        // random sweep over every code
        for (int i = 0; i < 400; i++) begin
            send(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            if (($urandom % 8) == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R2", "items left", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule